// File: doc/BRIEF.md
# Program Counter Sequencer with Halt and Verdict

This block keeps the program counter of a small von Neumann machine whose words are `DATA_W` bits wide and whose memory is byte addressed. In every cycle where an instruction is presented it chooses the next counter value. That value is either the sequential step of one instruction (two words, `2*DATA_W/8` bytes), an unconditional jump target, or a jump target taken on the flag being set or on the flag being clear. The block also handles the final instruction, which stops the machine.

The surrounding core presents three things with a valid strobe: the class of the instruction, its second operand and the current flag. Every instruction finishes in one clock. When the final instruction is issued, the counter freezes and the operand is captured as the program's return value. A verdict output rises only when that value is zero. After the halt, the block ignores all further instructions until a synchronous reset returns the counter to 0.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) leaves `pc_q` at 0 and `halted`, `accepted` and `ret_val` all at 0 after that edge.
- R2: A valid instruction of class code 0 (sequential), or of an unassigned code 5, 6 or 7, advances `pc_q` by `2*DATA_W/8` modulo 2^DATA_W at the next edge.
- R3: A valid instruction of class code 1 (jump) loads `pc_q` with `operand` at the next edge.
- R4: A valid instruction of class code 2 loads `operand` into `pc_q` when `flag_in` is 1, and otherwise takes the sequential step of R2.
- R5: A valid instruction of class code 3 loads `operand` into `pc_q` when `flag_in` is 0, and otherwise takes the sequential step of R2.
- R6: While `op_valid` is 0, `pc_q` keeps its value, whatever the other inputs are.
- R7: A valid instruction of class code 4 (answer) keeps `pc_q` unchanged, raises `halted` at the next edge, and captures `operand` into `ret_val`.
- R8: `accepted` is 1 only after an answer instruction whose operand was 0. An answer with a nonzero operand leaves `accepted` at 0.
- R9: While `halted` is 1, valid instructions have no effect: `pc_q`, `ret_val`, `accepted` and `halted` all hold until reset.
- R10: `pc_next` shows, in the same cycle, the value that `pc_q` will take at the coming edge when reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_class | input | 3 | Instruction class code (0 sequential, 1 jump, 2 jump if flag set, 3 jump if flag clear, 4 answer) |
| operand | input | DATA_W | Second operand: jump target or return value |
| flag_in | input | 1 | Current condition flag |
| pc_q | output | DATA_W | Registered program counter |
| pc_next | output | DATA_W | Counter value after the coming edge |
| halted | output | 1 | Machine stopped by an answer instruction |
| accepted | output | 1 | The answer returned zero |
| ret_val | output | DATA_W | Captured return value |

## Verification
`pc_next` is combinational, so it is due in the same cycle as the stimulus. `pc_q`, `halted`, `accepted` and `ret_val` each pass through one register and are due after the next rising edge. The bench changes its inputs on the falling edge and reads `pc_next` 2 ns later. It then waits for the rising edge and reads the registered outputs at the following falling edge, where it compares them with a model advanced by exactly one instruction.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;
   typedef enum logic [2:0] {
      PCU_OP_SEQ  = 3'd0,
      PCU_OP_JMP  = 3'd1,
      PCU_OP_JIF  = 3'd2,
      PCU_OP_JNIF = 3'd3,
      PCU_OP_ANS  = 3'd4
   } pcu_op_e;

   localparam int PCU_OP_W = 3;

   function automatic int pcu_step_bytes(input int data_w);
      return (2 * data_w) / 8;
   endfunction
endpackage

// File: rtl/pcu_step_adder.sv
`timescale 1ns/1ps
module pcu_step_adder #(
   parameter int DATA_W = 16,
   parameter int STEP   = 4
) (
   input  logic [DATA_W-1:0] base,
   output logic [DATA_W-1:0] sum
);
   localparam int STEP_LOG  = $clog2(STEP);
   localparam bit STEP_POW2 = (STEP == (1 << STEP_LOG));

   generate
      if (STEP < 1) begin : g_bad_step
         $error("pcu_step_adder: STEP must be positive");
      end

      if (STEP_POW2 && (STEP_LOG > 0) && (STEP_LOG < DATA_W)) begin : g_pow2
         // low bits never change for a power-of-two step: narrower carry chain
         localparam int HI_W = DATA_W - STEP_LOG;
         logic [HI_W-1:0] hi_inc;
         always_comb hi_inc = base[DATA_W-1:STEP_LOG] + HI_W'(1);
         assign sum = {hi_inc, base[STEP_LOG-1:0]};
      end else begin : g_full
         localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);
         assign sum = base + STEP_V;
      end
   endgenerate
endmodule

// File: rtl/pcu_target_mux.sv
`timescale 1ns/1ps
module pcu_target_mux
   import pcu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit ONEHOT_MUX = 1'b1
) (
   input  logic                issue,
   input  logic [PCU_OP_W-1:0] op_class,
   input  logic                flag_in,
   input  logic [DATA_W-1:0]   operand,
   input  logic [DATA_W-1:0]   cur_pc,
   input  logic [DATA_W-1:0]   seq_pc,
   output logic [DATA_W-1:0]   next_pc,
   output logic                ans_fire
);
   logic is_jmp, is_jif, is_jnif, is_ans;
   logic take_br, hold_pc;

   always_comb begin
      is_jmp  = (op_class == PCU_OP_JMP);
      is_jif  = (op_class == PCU_OP_JIF);
      is_jnif = (op_class == PCU_OP_JNIF);
      is_ans  = (op_class == PCU_OP_ANS);
      take_br = issue & (is_jmp | (is_jif & flag_in) | (is_jnif & ~flag_in));
      hold_pc = ~issue | is_ans;
      ans_fire = issue & is_ans;
   end

   generate
      if (ONEHOT_MUX) begin : g_andor
         logic sel_br, sel_hold, sel_seq;
         always_comb begin
            sel_br   = take_br;
            sel_hold = ~take_br & hold_pc;
            sel_seq  = ~take_br & ~hold_pc;
            next_pc  = ({DATA_W{sel_br}}   & operand)
                     | ({DATA_W{sel_hold}} & cur_pc)
                     | ({DATA_W{sel_seq}}  & seq_pc);
         end
      end else begin : g_prio
         always_comb begin
            if (take_br)      next_pc = operand;
            else if (hold_pc) next_pc = cur_pc;
            else              next_pc = seq_pc;
         end
      end
   endgenerate
endmodule

// File: rtl/pcu_halt_ctl.sv
`timescale 1ns/1ps
module pcu_halt_ctl #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ans_fire,
   input  logic [DATA_W-1:0] operand,
   output logic              halted,
   output logic              accepted,
   output logic [DATA_W-1:0] ret_val
);
   always_ff @(posedge clk) begin
      if (rst) begin
         halted   <= 1'b0;
         accepted <= 1'b0;
         ret_val  <= '0;
      end else if (ans_fire) begin
         halted   <= 1'b1;
         accepted <= (operand == '0);
         ret_val  <= operand;
      end
   end

   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted); // R9
   AST_RET_FROZEN: assert property (@(posedge clk) disable iff (rst)
      halted |=> ($stable(ret_val) && $stable(accepted))); // R9
   AST_ACCEPT_ZERO: assert property (@(posedge clk) disable iff (rst)
      accepted |-> (halted && (ret_val == '0))); // R8
   AST_REJECT_NONZERO: assert property (@(posedge clk) disable iff (rst)
      (halted && (ret_val != '0)) |-> !accepted); // R8
endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer
   import pcu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit ONEHOT_MUX = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                op_valid,
   input  logic [2:0]          op_class,
   input  logic [DATA_W-1:0]   operand,
   input  logic                flag_in,
   output logic [DATA_W-1:0]   pc_q,
   output logic [DATA_W-1:0]   pc_next,
   output logic                halted,
   output logic                accepted,
   output logic [DATA_W-1:0]   ret_val
);
   localparam int STEP = pcu_step_bytes(DATA_W);
   localparam logic [DATA_W-1:0] STEP_V = DATA_W'(STEP);

   generate
      if ((DATA_W < 8) || ((DATA_W % 8) != 0)) begin : g_bad_width
         $error("pc_sequencer: DATA_W must be a positive multiple of 8");
      end
   endgenerate

   logic [DATA_W-1:0] seq_pc;
   logic              issue;
   logic              ans_fire;

   assign issue = op_valid & ~halted;

   pcu_step_adder #(.DATA_W(DATA_W), .STEP(STEP)) u_step (
      .base (pc_q),
      .sum  (seq_pc)
   );

   pcu_target_mux #(.DATA_W(DATA_W), .ONEHOT_MUX(ONEHOT_MUX)) u_mux (
      .issue    (issue),
      .op_class (op_class),
      .flag_in  (flag_in),
      .operand  (operand),
      .cur_pc   (pc_q),
      .seq_pc   (seq_pc),
      .next_pc  (pc_next),
      .ans_fire (ans_fire)
   );

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end

   pcu_halt_ctl #(.DATA_W(DATA_W)) u_halt (
      .clk      (clk),
      .rst      (rst),
      .ans_fire (ans_fire),
      .operand  (operand),
      .halted   (halted),
      .accepted (accepted),
      .ret_val  (ret_val)
   );

   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !halted && (op_class == 3'd0 || op_class > 3'd4))
      |=> (pc_q == $past(pc_q) + STEP_V)); // R2
   AST_JMP_LOAD: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !halted && op_class == 3'd1) |=> (pc_q == $past(operand))); // R3
   AST_JIF_PATH: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !halted && op_class == 3'd2)
      |=> (pc_q == ($past(flag_in) ? $past(operand) : $past(pc_q) + STEP_V))); // R4
   AST_JNIF_PATH: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !halted && op_class == 3'd3)
      |=> (pc_q == ($past(flag_in) ? $past(pc_q) + STEP_V : $past(operand)))); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!op_valid || halted) |=> $stable(pc_q)); // R6
   AST_ANSWER_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !halted && op_class == 3'd4)
      |=> (halted && $stable(pc_q) && ret_val == $past(operand))); // R7
endmodule

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;
   localparam int W = 16;
   localparam logic [W-1:0] STEP = W'(2 * W / 8);

   logic         clk = 1'b0;
   logic         rst;
   logic         op_valid;
   logic [2:0]   op_class;
   logic [W-1:0] operand;
   logic         flag_in;
   logic [W-1:0] pc_q, pc_next, ret_val;
   logic         halted, accepted;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   logic [W-1:0] m_pc, m_ret;
   logic         m_halt, m_acc;

   always #10 clk = ~clk;

   pc_sequencer #(.DATA_W(W)) u0 (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_class(op_class),
      .operand(operand), .flag_in(flag_in), .pc_q(pc_q), .pc_next(pc_next),
      .halted(halted), .accepted(accepted), .ret_val(ret_val)
   );

   function automatic logic [W-1:0] f_next(input logic [W-1:0] pc, input logic h,
      input logic v, input logic [2:0] c, input logic [W-1:0] o, input logic f);
      if (!v || h) return pc;
      case (c)
         3'd1: return o;
         3'd2: return f ? o : pc + STEP;
         3'd3: return f ? pc + STEP : o;
         3'd4: return pc;
         default: return pc + STEP;
      endcase
   endfunction

   function automatic string f_tag(input logic v, input logic h, input logic [2:0] c);
      if (!v) return "R6";
      if (h) return "R9";
      case (c)
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         3'd4: return "R7";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic check_state(input string req);
      chk(pc_q === m_pc, req, pc_q, m_pc);
      chk(halted === m_halt, req, W'(halted), W'(m_halt));
      chk(ret_val === m_ret, req, ret_val, m_ret);
      chk(accepted === m_acc, "R8", W'(accepted), W'(m_acc));
   endtask

   task automatic do_reset();
      rst = 1'b1;
      op_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_pc = '0; m_halt = 1'b0; m_acc = 1'b0; m_ret = '0;
      check_state("R1");
   endtask

   task automatic step(input logic v, input logic [2:0] c, input logic [W-1:0] o,
                       input logic f);
      logic [W-1:0] exp_n;
      string tag;
      op_valid = v; op_class = c; operand = o; flag_in = f;
      exp_n = f_next(m_pc, m_halt, v, c, o, f);
      tag = f_tag(v, m_halt, c);
      #2;
      chk(pc_next === exp_n, "R10", pc_next, exp_n);
      @(posedge clk);
      @(negedge clk);
      if (v && !m_halt && c == 3'd4) begin
         m_halt = 1'b1; m_ret = o; m_acc = (o == '0);
      end
      m_pc = exp_n;
      check_state(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int since_halt;
      void'($urandom(32'd20240611));
      rst = 1'b1; op_valid = 1'b0; op_class = '0; operand = '0; flag_in = 1'b0;
      @(negedge clk);
      do_reset();                              // R1
      step(1, 3'd0, 16'h1234, 0);              // R2 sequential
      step(1, 3'd1, 16'hFFFC, 0);              // R3 jump near top
      step(1, 3'd0, 16'h0000, 1);              // R2 wrap to 0
      step(1, 3'd6, 16'hAAAA, 1);              // R2 unassigned code
      step(1, 3'd2, 16'h0100, 0);              // R4 not taken
      step(1, 3'd2, 16'h0100, 1);              // R4 taken
      step(1, 3'd3, 16'h0200, 1);              // R5 not taken
      step(1, 3'd3, 16'h0200, 0);              // R5 taken
      step(0, 3'd1, 16'h7777, 1);              // R6 idle
      step(1, 3'd4, 16'h0005, 0);              // R7 answer, reject (R8)
      step(1, 3'd1, 16'h4444, 0);              // R9 ignored
      step(1, 3'd4, 16'h0000, 0);              // R9 second answer ignored
      do_reset();                              // R1 from halted
      step(1, 3'd0, 16'h0000, 0);
      step(1, 3'd4, 16'h0000, 1);              // R8 accept
      step(1, 3'd0, 16'h0000, 0);              // R9
      do_reset();

      since_halt = 0;
      for (int i = 0; i < 600; i++) begin
         logic [2:0] c;
         logic [W-1:0] o;
         if (m_halt) begin
            since_halt++;
            if (since_halt > 3) begin
               do_reset();
               since_halt = 0;
            end
         end
         c = 3'($urandom_range(0, 7));
         if (c == 3'd4 && $urandom_range(0, 5) != 0) c = 3'd0;
         o = ($urandom_range(0, 3) == 0) ? '0 : W'($urandom);
         step($urandom_range(0, 7) != 0, c, o, 1'($urandom_range(0, 1)));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule